// File: doc/BRIEF.md
# Receive Flow Control with Hysteresis

This block drives the active-low request-to-send (RTS) pin of a serial receiver from the fill level of its receive FIFO. A single 8-bit threshold register holds two 4-bit levels, each counted in units of four characters: a halt level and a resume level. When automatic flow control is on, the block sends RTS inactive (high) once the FIFO fill reaches the halt level. It keeps RTS inactive until the fill drains down to the resume level. Between the two levels the pin keeps its previous state, which gives the hysteresis.

Software has to program the thresholds before it turns automatic control on. The block does not check that the halt level lies above the resume level. When automatic control is off, the pin follows the software RTS request and the halt flag stays clear.

Top module: `rx_flow_ctrl`

## Requirements
- R1: After reset the threshold register is 0x00 and the internal halted state is clear. With auto_en_i=0 and sw_rts_i=0 this gives rts_no=1 and halt_o=0.
- R2: When cfg_we_i=1, a clock edge loads cfg_wdata_i into the threshold register. Bits [3:0] are the halt nibble and bits [7:4] are the resume nibble. Each level in characters is its nibble times four, so the range is 0 to 60.
- R3: If auto_en_i=1 and fill_i is at or above the halt level at a clock edge, then from the next cycle rts_no=1 and halt_o=1.
- R4: If auto_en_i=1 and fill_i is below the halt level and at or below the resume level at a clock edge, then from the next cycle rts_no=0 and halt_o=0.
- R5: If auto_en_i=1 and fill_i lies strictly between the resume and halt levels, the halted state does not change at that edge.
- R6: With auto_en_i=0, rts_no equals the inverse of sw_rts_i in the same cycle and halt_o=0. With auto_en_i=1, sw_rts_i has no effect on rts_no.
- R7: Each edge with auto_en_i=0 clears the halted state. After a re-enable, RTS therefore starts active and is judged again against the current fill level.
- R8: The halt comparison takes priority over the resume comparison. If the levels are written out of order (halt ≤ resume), a fill at or above the halt level still halts.
- R9: A halt nibble of 0 halts whenever automatic control is on, including at an empty FIFO.
- R10: The top level of 60 (halt nibble 0xF) halts at fill 60 and above, including a full 64-entry FIFO, and does not halt at 59.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the threshold register |
| cfg_wdata_i | input | 8 | Threshold data: resume nibble [7:4], halt nibble [3:0] |
| auto_en_i | input | 1 | Enables automatic RTS control |
| sw_rts_i | input | 1 | Software RTS request (1 = assert RTS) |
| fill_i | input | CNT_W (7) | Current receive FIFO fill level |
| rts_no | output | 1 | RTS pin, active low |
| halt_o | output | 1 | 1 while RTS is held inactive by the halt level |

## Verification
The hardest state to reach is a fill level inside the hysteresis band while the block is halted. Reaching it takes an ordered walk: first up to the halt level, then down into the band. The stimulus makes that walk, rises again from a resumed state into the band, and toggles the software request inside the band to show it has no effect. It also reprograms the register with inverted levels, a zero halt level and the 60-character ceiling, and disables and re-enables the block in the middle of a halt.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam int unsigned NIB_W = 4;

  typedef struct packed {
    logic [NIB_W-1:0] resume;
    logic [NIB_W-1:0] halt;
  } rfc_cfg_t;
endpackage

// File: rtl/rfc_cfg_reg.sv
module rfc_cfg_reg
  import rfc_pkg::*;
#(
  parameter int unsigned CNT_W      = 7,
  parameter int unsigned STEP_SHIFT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  rfc_cfg_t         wdata_i,
  output logic [CNT_W-1:0] halt_lvl_o,
  output logic [CNT_W-1:0] resume_lvl_o
);
  rfc_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= wdata_i;
  end

  // nibble counts groups of 2**STEP_SHIFT characters
  assign halt_lvl_o   = CNT_W'(cfg_q.halt)   << STEP_SHIFT;
  assign resume_lvl_o = CNT_W'(cfg_q.resume) << STEP_SHIFT;
endmodule

// File: rtl/rfc_hyst.sv
module rfc_hyst #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] fill_i,
  input  logic [CNT_W-1:0] halt_lvl_i,
  input  logic [CNT_W-1:0] resume_lvl_i,
  output logic             halted_o
);
  logic halted_q, halted_d;

  always_comb begin
    halted_d = halted_q;
    if (!en_i)                       halted_d = 1'b0;
    else if (fill_i >= halt_lvl_i)   halted_d = 1'b1;  // halt wins on misordered levels
    else if (fill_i <= resume_lvl_i) halted_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) halted_q <= 1'b0;
    else         halted_q <= halted_d;
  end

  assign halted_o = halted_q;
endmodule

// File: rtl/rx_flow_ctrl.sv
module rx_flow_ctrl
  import rfc_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned STEP_SHIFT = 2,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [7:0]       cfg_wdata_i,
  input  logic             auto_en_i,
  input  logic             sw_rts_i,
  input  logic [CNT_W-1:0] fill_i,
  output logic             rts_no,
  output logic             halt_o
);
  logic [CNT_W-1:0] halt_lvl, resume_lvl;
  logic             halted;

  rfc_cfg_reg #(.CNT_W(CNT_W), .STEP_SHIFT(STEP_SHIFT)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .wdata_i     (rfc_cfg_t'(cfg_wdata_i)),
    .halt_lvl_o  (halt_lvl),
    .resume_lvl_o(resume_lvl)
  );

  rfc_hyst #(.CNT_W(CNT_W)) u_hyst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (auto_en_i),
    .fill_i      (fill_i),
    .halt_lvl_i  (halt_lvl),
    .resume_lvl_i(resume_lvl),
    .halted_o    (halted)
  );

  assign rts_no = auto_en_i ? halted : ~sw_rts_i;
  assign halt_o = auto_en_i & halted;
endmodule

// File: rtl/rx_flow_ctrl_chk.sv
module rx_flow_ctrl_chk #(
  parameter int unsigned CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             auto_en_i,
  input logic             sw_rts_i,
  input logic [CNT_W-1:0] fill_i,
  input logic [CNT_W-1:0] halt_lvl,
  input logic [CNT_W-1:0] resume_lvl,
  input logic             rts_no,
  input logic             halt_o
);
  p_halt_at_level_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && fill_i >= halt_lvl) |=> (!auto_en_i || (halt_o && rts_no)));

  p_resume_at_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && fill_i < halt_lvl && fill_i <= resume_lvl) |=> (!auto_en_i || (!halt_o && !rts_no)));

  p_band_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && fill_i < halt_lvl && fill_i > resume_lvl) |=> (!auto_en_i || $stable(halt_o)));

  p_sw_passthru_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |-> (rts_no == !sw_rts_i && !halt_o));

  p_pin_matches_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_en_i |-> (rts_no == halt_o));

  p_reenable_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |=> (!auto_en_i || !rts_no));
endmodule

bind rx_flow_ctrl rx_flow_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .auto_en_i (auto_en_i),
  .sw_rts_i  (sw_rts_i),
  .fill_i    (fill_i),
  .halt_lvl  (halt_lvl),
  .resume_lvl(resume_lvl),
  .rts_no    (rts_no),
  .halt_o    (halt_o)
);

// File: tb/rx_flow_ctrl_bench.sv
`timescale 1ns/1ps
module rx_flow_ctrl_bench;
  localparam int CNT_W = 7;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_we_i = 1'b0;
  logic [7:0]       cfg_wdata_i = '0;
  logic             auto_en_i = 1'b0;
  logic             sw_rts_i = 1'b0;
  logic [CNT_W-1:0] fill_i = '0;
  logic             rts_no, halt_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic  rts;
    logic  halt;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  // requirement model
  logic [7:0] m_cfg = 8'h00;
  logic       m_halted = 1'b0;
  logic       done = 1'b0;

  always #4 clk_i = ~clk_i;

  rx_flow_ctrl u_rx_flow_ctrl (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_wdata_i, .auto_en_i,
    .sw_rts_i, .fill_i, .rts_no, .halt_o
  );

  task automatic check(input logic act_r, act_h, exp_r, exp_h, input string tag);
    checks++;
    if (act_r !== exp_r || act_h !== exp_h) begin
      errors++;
      $display("FAIL %s: rts_no=%b halt_o=%b expected rts_no=%b halt_o=%b",
               tag, act_r, act_h, exp_r, exp_h);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] wd, input logic en,
                      input logic sw, input int fill, input string tag);
    int hl, rl;
    exp_t e;
    @(negedge clk_i);
    cfg_we_i = we; cfg_wdata_i = wd; auto_en_i = en; sw_rts_i = sw;
    fill_i = CNT_W'(fill);
    hl = int'(m_cfg[3:0]) * 4;
    rl = int'(m_cfg[7:4]) * 4;
    if (!en)            m_halted = 1'b0;
    else if (fill >= hl) m_halted = 1'b1;
    else if (fill <= rl) m_halted = 1'b0;
    if (we) m_cfg = wd;
    e.rts  = en ? m_halted : ~sw;
    e.halt = en & m_halted;
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  // monitor: after each edge compares against the oldest expectation
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(rts_no, halt_o, e.rts, e.halt, e.tag);
      end
    end
  end

  initial begin
    #20;
    check(rts_no, halt_o, 1'b1, 1'b0, "R1 reset");
    @(negedge clk_i);
    rst_ni = 1'b1;

    step(0, 8'h00, 0, 1, 0,  "R6 sw assert");
    step(0, 8'h00, 0, 0, 50, "R6 sw deassert");
    step(1, 8'h48, 0, 1, 0,  "R2 write halt 32 resume 16");
    step(0, 8'h00, 1, 1, 10, "R4 low fill active");
    step(0, 8'h00, 1, 1, 31, "R2 below halt");
    step(0, 8'h00, 1, 1, 32, "R3 halt at level");
    step(0, 8'h00, 1, 1, 20, "R5 band holds halt");
    step(0, 8'h00, 1, 0, 17, "R6 sw ignored in band");
    step(0, 8'h00, 1, 1, 16, "R4 resume at level");
    step(0, 8'h00, 1, 0, 25, "R5 band holds active");
    step(0, 8'h00, 1, 0, 40, "R3 halt above level");
    step(0, 8'h00, 0, 1, 40, "R7 disable clears");
    step(0, 8'h00, 1, 1, 20, "R7 reenable band active");
    step(1, 8'h33, 1, 1, 5,  "R2 write equal levels");
    step(0, 8'h00, 1, 1, 12, "R8 halt priority");
    step(0, 8'h00, 1, 1, 11, "R8 resume below");
    step(1, 8'h20, 1, 1, 3,  "R2 write halt 0");
    step(0, 8'h00, 1, 1, 0,  "R9 zero halt at empty");
    step(1, 8'h0F, 0, 1, 0,  "R2 write halt 60");
    step(0, 8'h00, 1, 1, 59, "R10 below ceiling");
    step(0, 8'h00, 1, 1, 60, "R10 at ceiling");
    step(0, 8'h00, 1, 1, 64, "R10 full fifo");
    step(0, 8'h00, 1, 1, 1,  "R5 band wide hold");
    step(0, 8'h00, 1, 1, 0,  "R4 resume at 0");
    @(posedge clk_i);
    @(posedge clk_i);
    #3;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule